// File: doc/BRIEF.md
# Compound Partial Product Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It does not use an AND array of N×N partial-product bits. Each row i looks at the operand bit pair (a[i], b[i]) and chooses one of four candidates:

- zero;
- the low i bits of the multiplier;
- the low i bits of the multiplicand;
- the low i+1 bits of the operand sum A+B.

One adder forms A+B, and every row reads it. A separate diagonal word carries the square terms a[i]·b[i]·2^(2i). A combinational adder tree then adds the rows and the diagonal word. Row i holds at most i+1 bits, so the design has about half as many partial-product bits as an AND array.

The result enters a register that loads when the input strobe is high. That register has two named conditions:

- **EMPTY**: `out_valid` is low. This holds after reset, and again after any cycle with no strobe.
- **LOADED**: `out_valid` is high.

The register moves between them as follows:

- EMPTY→LOADED or LOADED→LOADED happens on each strobed cycle.
- LOADED→EMPTY happens on the first cycle without a strobe. The product value is kept.

When the parameter `REG_OUT` is 0, the register is removed and the product is combinational.

Top module: `cpp_mult`

## Requirements
- R1: `product` equals the unsigned value a×b, exact in 2N bits, for every pair of operands.
- R2: Row i (i≥1) is selected by the code {a[i],b[i]}, with the row value weighted by 2^i:
  - 2'b00 gives zero;
  - 2'b10 gives b[i-1:0];
  - 2'b01 gives a[i-1:0];
  - 2'b11 gives (a+b)[i:0].
- R3: Whenever a[i] and b[i] are both 1, one extra bit of weight 2^(2i) is added. Row 0 consists of this bit only.
- R4: One shared N+1-bit adder forms a+b. No row value, once weighted, reaches 2^(2i+1).
- R5: If either operand is zero, the product is zero.
- R6: With `REG_OUT`=1, `out_valid` in a cycle equals `in_valid` from the previous clock edge. The product computed from strobed operands appears after exactly one edge.
- R7: With `REG_OUT`=1, `product` stays unchanged across any edge where `in_valid` is low, even if the operands change.
- R8: While `rst_n` is low, `product` is 0 and `out_valid` is 0.
- R9: All-ones operands give (2^N−1)².

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe; loads the output register |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| product | output | 2N | Unsigned product a×b |
| out_valid | output | 1 | High one cycle after a strobed operand pair |

## Verification
The bench runs every operand pair at N=4. This reaches all four row codes in every row position. A wrong candidate mapping, such as swapping the two slice choices, would give wrong products for asymmetric operands. Other corner cases and the faults they expose:

- **Both bits of a pair set:** catches a dropped or misplaced diagonal bit, or a sum slice truncated one bit short, because the top carry of the sum would be lost.
- **All-ones operands at N=8 and N=16:** expose truncation in the widest rows of the tree.
- **A zero operand:** exposes a row that leaks a non-zero candidate.
- **Cycles without a strobe:** show whether the output register wrongly loads new operands or drops `out_valid` at the wrong edge.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

    // Row selection code, formed as {a[i], b[i]}
    typedef enum logic [1:0] {
        SEL_ZERO  = 2'b00,
        SEL_MCAND = 2'b01,   // only b[i] set: take multiplicand slice
        SEL_MPLR  = 2'b10,   // only a[i] set: take multiplier slice
        SEL_SUM   = 2'b11    // both set: take operand-sum slice
    } cpp_sel_e;

    function automatic int unsigned tree_leaves(int unsigned n);
        int unsigned p;
        p = 1;
        while (p < n) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/cpp_row.sv
module cpp_row
    import cpp_pkg::*;
#(
    parameter int unsigned N   = 8,
    parameter int unsigned IDX = 1
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    input  logic [N:0]     sum_ab,
    output logic [2*N-1:0] row
);
    localparam int unsigned PW = 2 * N;

    generate
        if (IDX == 0) begin : g_first
            // Row 0 has no lower slices; its only content is the diagonal bit.
            assign row = '0;
        end else begin : g_rest
            localparam int unsigned CW = IDX + 1;
            cpp_sel_e        sel;
            logic [CW-1:0]   cand;

            always_comb begin
                sel = cpp_sel_e'({a[IDX], b[IDX]});
                unique case (sel)
                    SEL_ZERO:  cand = '0;
                    SEL_MPLR:  cand = {1'b0, b[IDX-1:0]};
                    SEL_MCAND: cand = {1'b0, a[IDX-1:0]};
                    SEL_SUM:   cand = sum_ab[IDX:0];
                    default:   cand = '0;
                endcase
                row = PW'(cand) << IDX;
            end

            // R4: weighted row never reaches 2^(2i+1)
            always_comb begin
                assert_row_bound_R4: assert ((row >> (2 * IDX + 1)) == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/cpp_reduce.sv
module cpp_reduce
    import cpp_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0][2*N-1:0] rows,
    input  logic [2*N-1:0]        diag,
    output logic [2*N-1:0]        total
);
    localparam int unsigned PW     = 2 * N;
    localparam int unsigned LEAVES = tree_leaves(N + 1);
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    logic [PW-1:0] node [NODES];

    generate
        for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
            if (k < N) begin : g_row
                assign node[LEAVES-1+k] = rows[k];
            end else if (k == N) begin : g_diag
                assign node[LEAVES-1+k] = diag;
            end else begin : g_pad
                assign node[LEAVES-1+k] = '0;
            end
        end
        for (genvar j = 0; j < LEAVES - 1; j++) begin : g_add
            assign node[j] = node[2*j+1] + node[2*j+2];
        end
    endgenerate

    assign total = node[0];

endmodule

// File: rtl/cpp_mult.sv
module cpp_mult
    import cpp_pkg::*;
#(
    parameter int unsigned N       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] product,
    output logic           out_valid
);
    localparam int unsigned PW = 2 * N;

    logic [N:0]           sum_ab;
    logic [N-1:0][PW-1:0] rows;
    logic [PW-1:0]        diag;
    logic [PW-1:0]        product_c;

    // R4: the single shared operand adder
    assign sum_ab = {1'b0, a} + {1'b0, b};

    // R3: square terms at distinct even positions
    always_comb begin
        diag = '0;
        for (int i = 0; i < N; i++) begin
            diag[2*i] = a[i] & b[i];
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            cpp_row #(.N(N), .IDX(i)) u_row (
                .a      (a),
                .b      (b),
                .sum_ab (sum_ab),
                .row    (rows[i])
            );
        end
    endgenerate

    cpp_reduce #(.N(N)) u_reduce (
        .rows  (rows),
        .diag  (diag),
        .total (product_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    product   <= '0;
                    out_valid <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) product <= product_c;
                end
            end

            assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(product));
            assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (product == PW'($past(a)) * PW'($past(b))));
            assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (a == '0 || b == '0)) |=> (product == '0));
        end else begin : g_comb
            assign product   = product_c;
            assign out_valid = in_valid;
        end
    endgenerate

endmodule

// File: tb/sim_cpp_mult.sv
module sim_cpp_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] a16 = '0, b16 = '0;
    logic [7:0]  p4;
    logic [15:0] p8;
    logic [31:0] p16;
    logic        v4, v8, v16;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpp_mult #(.N(8))  u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a8),  .b(b8),  .product(p8),  .out_valid(v8));
    cpp_mult #(.N(4))  u1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a4),  .b(b4),  .product(p4),  .out_valid(v4));
    cpp_mult #(.N(16)) u2 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a16), .b(b16), .product(p16), .out_valid(v16));

    function automatic logic [63:0] ref_mul(logic [63:0] x, logic [63:0] y);
        return x * y;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, capture at posedge, sample at following negedge
    task automatic apply(logic [15:0] x, logic [15:0] y, bit vld);
        a4 = x[3:0];  b4 = y[3:0];
        a8 = x[7:0];  b8 = y[7:0];
        a16 = x;      b16 = y;
        in_valid = vld;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mul_all(string req, logic [15:0] x, logic [15:0] y);
        apply(x, y, 1'b1);
        chk(req, 64'(p4),  ref_mul(64'(x[3:0]), 64'(y[3:0])));
        chk(req, 64'(p8),  ref_mul(64'(x[7:0]), 64'(y[7:0])));
        chk(req, 64'(p16), ref_mul(64'(x), 64'(y)));
        chk("R6", 64'({v4, v8, v16}), 64'(3'b111));
    endtask

    initial begin
        logic [15:0] hold8;
        logic [31:0] hold16;
        void'($urandom(32'd1234));
        @(negedge clk);
        // R8: reset state
        chk("R8", 64'(p8), 64'd0);
        chk("R8", 64'(p16), 64'd0);
        chk("R8", 64'({v4, v8, v16}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3: exhaustive at N=4 covers every row code
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply(16'(x), 16'(y), 1'b1);
                chk("R1_R2_R3", 64'(p4), ref_mul(64'(x), 64'(y)));
            end
        end

        // R5: zero operands
        mul_all("R5", 16'h0000, 16'hBEEF);
        mul_all("R5", 16'hA5C3, 16'h0000);
        mul_all("R5", 16'h0000, 16'h0000);
        // R9: all ones
        mul_all("R9", 16'hFFFF, 16'hFFFF);
        chk("R9", 64'(p16), 64'hFFFE0001);
        // R3: every pair both set, and disjoint bits (no diagonal)
        mul_all("R3", 16'hAAAA, 16'hAAAA);
        mul_all("R2", 16'hAAAA, 16'h5555);
        mul_all("R2", 16'h8001, 16'h7FFE);

        // R1: random
        for (int k = 0; k < 3000; k++) begin
            mul_all("R1", 16'($urandom), 16'($urandom));
        end

        // R7: hold when strobe low; R6: valid drops
        mul_all("R7", 16'h1234, 16'h4321);
        hold8 = p8;
        hold16 = p16;
        apply(16'hFFFF, 16'h7777, 1'b0);
        chk("R7", 64'(p8), 64'(hold8));
        chk("R7", 64'(p16), 64'(hold16));
        chk("R6", 64'({v4, v8, v16}), 64'd0);
        apply(16'h0F0F, 16'h0001, 1'b0);
        chk("R7", 64'(p16), 64'(hold16));
        mul_all("R6", 16'h00FF, 16'h0101);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule